// File: doc/BRIEF.md
# Serial Register-Access Slave Controller

This block is the slave end of a bit-serial register protocol, seen at the bit level rather than the line level. The master marks the opening of every frame with a one-cycle start strobe. It then clocks each bit slot with a one-cycle bit-valid strobe. Master-driven slots carry their value on the input bit. In slave-driven slots the block places its value on the output bit and raises the drive-enable. The frame header is a 3-bit device number, then a 5-bit register address, then a direction bit. The block compares the device number against a static own-address input. It then either returns register contents, accepts new contents, or stays silent until the next start strobe.

Reads return data MSB first, followed by an even-parity bit that covers the whole frame, and then the master's acknowledge. Writes carry data and a master-sent parity bit, and the block answers with its own acknowledge. Any failed exchange sets a sticky bus-error flag in the status register and raises an attention-request output. The master uses that output to find the device that needs service. Device number 000 addresses all devices. This block answers it only for writes to the control register.

Top module: `srl_slave`

## Requirements
- R1: A frame is a start strobe and then, on successive bit-valid strobes, the device number (3 bits, MSB first), the register address (5 bits, MSB first) and a direction bit (1 = read, 0 = write). A frame is addressed when the device number equals `dev_addr_i` and is not 000. The slave's value for a slave-driven slot is on `bit_o`/`bit_oe_o` from the cycle after the previous strobe through the strobe of that slot. `bit_oe_o` is 0 in every master-driven slot and outside frames.
- R2: A read with device number 000, or with any device number other than `dev_addr_i`, is ignored: `bit_oe_o` stays 0 through the whole frame and no register changes.
- R3: On an addressed read the slave drives the register contents MSB first. Addresses 2 and 3 are 16-bit data registers. Address 0 is the 8-bit control register and address 1 is the 8-bit status register, whose bit 0 is the bus-error flag and whose other bits read 0. Every other address reads as 8 zero bits.
- R4: After the read data the slave drives one parity bit. It makes the count of ones over device number, address, direction bit, data and the parity bit itself even.
- R5: The last read slot is the master's acknowledge (1 = good, 0 = error) and is not driven by the slave. An acknowledge of 0 on an addressed read sets status bit 0. That bit stays 1 until a write to address 1 with data bit 0 equal to 1; a write with data bit 0 equal to 0 leaves it set.
- R6: On an accepted write the master sends the data (MSB first) and then a parity bit; the slave then drives an acknowledge slot. If the frame parity is even, the slave drives 1 and stores the data. Otherwise it drives 0, stores nothing and sets status bit 0.
- R7: A write with device number 000 is accepted only when it addresses register 0. Broadcast writes to any other address are ignored, with no slot driven and no register changed.
- R8: `attn_o` rises in the cycle after an acknowledge slot that sets the bus-error flag. It stays 1 until the cycle after the next start strobe.
- R9: A start strobe in the middle of a frame abandons that frame without storing anything and begins decoding a new header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dev_addr_i | input | 3 | Static own device number |
| start_i | input | 1 | One-cycle frame start strobe |
| bit_vld_i | input | 1 | One-cycle bit-slot strobe |
| bit_i | input | 1 | Master-driven bit value, sampled with `bit_vld_i` |
| bit_o | output | 1 | Slave-driven bit value |
| bit_oe_o | output | 1 | Slave drives the current slot |
| attn_o | output | 1 | Attention request |

## Verification
Each slave-driven slot value is due in the cycle after the strobe of the preceding slot and is held through its own strobe. The bench's monitor therefore samples `bit_o` and `bit_oe_o` at the falling edge of each strobe cycle, against an expectation pushed when that strobe was raised. Register updates and the bus-error flag take effect at the edge that ends the acknowledge slot, so they are checked through later read frames rather than at a fixed cycle. `attn_o` is checked one cycle after the failing acknowledge strobe and one cycle after each start strobe.

// File: rtl/srl_pkg.sv
package srl_pkg;
  localparam int SRL_DEV_W     = 3;
  localparam int SRL_ADDR_W    = 5;
  localparam int SRL_DATA_W    = 16;
  localparam int SRL_NARROW_W  = 8;
  localparam int SRL_CTRL_ADDR = 0;
  localparam int SRL_STAT_ADDR = 1;
  localparam int SRL_WIDE_BASE = 2;
  localparam int SRL_N_WIDE    = 2;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_SKIP, S_RDD, S_RDP, S_RDA, S_WRD, S_WRP, S_WRA
  } srl_state_t;

  function automatic logic srl_is_wide(input int addr, input int base, input int cnt);
    return (addr >= base) && (addr < base + cnt);
  endfunction
endpackage

// File: rtl/srl_rst_sync.sv
module srl_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/srl_frame.sv
module srl_frame
  import srl_pkg::*;
#(
  parameter int DEV_W     = SRL_DEV_W,
  parameter int ADDR_W    = SRL_ADDR_W,
  parameter int DATA_W    = SRL_DATA_W,
  parameter int NARROW_W  = SRL_NARROW_W,
  parameter int CTRL_ADDR = SRL_CTRL_ADDR,
  parameter int WIDE_BASE = SRL_WIDE_BASE,
  parameter int N_WIDE    = SRL_N_WIDE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEV_W-1:0]  dev_addr_i,
  input  logic              start_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              ber_set_o,
  output logic              bit_o,
  output logic              bit_oe_o
);
  localparam int HDR_W = DEV_W + ADDR_W + 1;
  localparam int CNT_W = $clog2((HDR_W > DATA_W ? HDR_W : DATA_W) + 1);
  localparam int ALIGN = DATA_W - NARROW_W;

  srl_state_t        st_q, st_d;
  logic [HDR_W-1:0]  hdr_q, hdr_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              par_q, par_d;
  logic              wide_q, wide_d;
  logic              ok_q, ok_d;

  // header fields seen while the last header bit arrives
  logic [DEV_W-1:0]  dec_dev;
  logic [ADDR_W-1:0] dec_addr;
  logic              dec_own, dec_bcast, dec_wide;
  logic [CNT_W-1:0]  last_cnt;

  assign dec_dev   = hdr_q[HDR_W-2 -: DEV_W];
  assign dec_addr  = hdr_q[ADDR_W-1:0];
  assign dec_own   = (dec_dev == dev_addr_i) && (dec_dev != '0);
  assign dec_bcast = (dec_dev == '0);
  assign dec_wide  = srl_is_wide(int'(dec_addr), WIDE_BASE, N_WIDE);
  assign last_cnt  = wide_q ? CNT_W'(DATA_W - 1) : CNT_W'(NARROW_W - 1);

  assign reg_addr_o = (st_q == S_HDR) ? dec_addr : hdr_q[ADDR_W:1];
  assign wr_data_o  = sh_q;

  always_comb begin
    st_d      = st_q;
    hdr_d     = hdr_q;
    sh_d      = sh_q;
    cnt_d     = cnt_q;
    par_d     = par_q;
    wide_d    = wide_q;
    ok_d      = ok_q;
    wr_en_o   = 1'b0;
    ber_set_o = 1'b0;
    if (start_i) begin
      st_d  = S_HDR;
      hdr_d = '0;
      cnt_d = '0;
      par_d = 1'b0;
    end else if (bit_vld_i) begin
      unique case (st_q)
        S_HDR: begin
          hdr_d = {hdr_q[HDR_W-2:0], bit_i};
          par_d = par_q ^ bit_i;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(HDR_W - 1)) begin
            cnt_d  = '0;
            wide_d = dec_wide;
            if (bit_i) begin
              if (dec_own) begin
                st_d = S_RDD;
                sh_d = dec_wide ? rd_data_i : (rd_data_i << ALIGN);
              end else begin
                st_d = S_SKIP;
              end
            end else if (dec_own || (dec_bcast && (int'(dec_addr) == CTRL_ADDR))) begin
              st_d = S_WRD;
              sh_d = '0;
            end else begin
              st_d = S_SKIP;
            end
          end
        end
        S_RDD: begin
          sh_d  = sh_q << 1;
          par_d = par_q ^ sh_q[DATA_W-1];
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == last_cnt) st_d = S_RDP;
        end
        S_RDP: st_d = S_RDA;
        S_RDA: begin
          ber_set_o = ~bit_i;
          st_d      = S_IDLE;
        end
        S_WRD: begin
          sh_d  = {sh_q[DATA_W-2:0], bit_i};
          par_d = par_q ^ bit_i;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == last_cnt) st_d = S_WRP;
        end
        S_WRP: begin
          ok_d = ~(par_q ^ bit_i);
          st_d = S_WRA;
        end
        S_WRA: begin
          wr_en_o   = ok_q;
          ber_set_o = ~ok_q;
          st_d      = S_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      hdr_q  <= '0;
      sh_q   <= '0;
      cnt_q  <= '0;
      par_q  <= 1'b0;
      wide_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      hdr_q  <= hdr_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      par_q  <= par_d;
      wide_q <= wide_d;
      ok_q   <= ok_d;
    end
  end

  always_comb begin
    bit_oe_o = 1'b0;
    bit_o    = 1'b0;
    unique case (st_q)
      S_RDD:   begin bit_oe_o = 1'b1; bit_o = sh_q[DATA_W-1]; end
      S_RDP:   begin bit_oe_o = 1'b1; bit_o = par_q;          end
      S_WRA:   begin bit_oe_o = 1'b1; bit_o = ok_q;           end
      default: ;
    endcase
  end

  // R2
  bcast_rd_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_RDD) || (st_q == S_RDP)) |-> (hdr_q[HDR_W-1 -: DEV_W] != '0));

  // R1
  drive_only_addressed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_oe_o |-> (hdr_q[HDR_W-1 -: DEV_W] == dev_addr_i) || (hdr_q[HDR_W-1 -: DEV_W] == '0));
endmodule

// File: rtl/srl_regs.sv
module srl_regs
  import srl_pkg::*;
#(
  parameter int ADDR_W    = SRL_ADDR_W,
  parameter int DATA_W    = SRL_DATA_W,
  parameter int NARROW_W  = SRL_NARROW_W,
  parameter int CTRL_ADDR = SRL_CTRL_ADDR,
  parameter int STAT_ADDR = SRL_STAT_ADDR,
  parameter int WIDE_BASE = SRL_WIDE_BASE,
  parameter int N_WIDE    = SRL_N_WIDE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ber_set_i
);
  logic [NARROW_W-1:0] ctrl_q, ctrl_d;
  logic                ber_q, ber_d;
  logic [DATA_W-1:0]   wide_q [N_WIDE];
  logic                hit_ctrl, hit_stat;

  assign hit_ctrl = (int'(addr_i) == CTRL_ADDR);
  assign hit_stat = (int'(addr_i) == STAT_ADDR);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en_i && hit_ctrl) ctrl_d = wr_data_i[NARROW_W-1:0];
    ber_d = ber_q;
    if (ber_set_i)                             ber_d = 1'b1;
    else if (wr_en_i && hit_stat && wr_data_i[0]) ber_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ber_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      ber_q  <= ber_d;
    end
  end

  for (genvar gi = 0; gi < N_WIDE; gi++) begin : g_wide
    logic [DATA_W-1:0] nxt;
    always_comb begin
      nxt = wide_q[gi];
      if (wr_en_i && (int'(addr_i) == WIDE_BASE + gi)) nxt = wr_data_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wide_q[gi] <= '0;
      else        wide_q[gi] <= nxt;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (hit_ctrl)      rd_data_o = {{(DATA_W-NARROW_W){1'b0}}, ctrl_q};
    else if (hit_stat) rd_data_o = {{(DATA_W-1){1'b0}}, ber_q};
    for (int i = 0; i < N_WIDE; i++)
      if (int'(addr_i) == WIDE_BASE + i) rd_data_o = wide_q[i];
  end

  // R5
  ber_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ber_set_i |=> ber_q);

  // R6
  commit_vs_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |-> !ber_set_i);
endmodule

// File: rtl/srl_attn.sv
module srl_attn (
  input  logic clk,
  input  logic rst_n,
  input  logic err_i,
  input  logic start_i,
  output logic attn_o
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (start_i)    pend_d = 1'b0;
    else if (err_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign attn_o = pend_q;

  // R8
  attn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !attn_o);

  // R8
  attn_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(attn_o) |-> $past(err_i));
endmodule

// File: rtl/srl_slave.sv
module srl_slave
  import srl_pkg::*;
#(
  parameter int DEV_W     = SRL_DEV_W,
  parameter int ADDR_W    = SRL_ADDR_W,
  parameter int DATA_W    = SRL_DATA_W,
  parameter int NARROW_W  = SRL_NARROW_W,
  parameter int CTRL_ADDR = SRL_CTRL_ADDR,
  parameter int STAT_ADDR = SRL_STAT_ADDR,
  parameter int WIDE_BASE = SRL_WIDE_BASE,
  parameter int N_WIDE    = SRL_N_WIDE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEV_W-1:0] dev_addr_i,
  input  logic             start_i,
  input  logic             bit_vld_i,
  input  logic             bit_i,
  output logic             bit_o,
  output logic             bit_oe_o,
  output logic             attn_o
);
  logic              rst_n_s;
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en, ber_set;

  srl_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  srl_frame #(
    .DEV_W(DEV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NARROW_W(NARROW_W),
    .CTRL_ADDR(CTRL_ADDR), .WIDE_BASE(WIDE_BASE), .N_WIDE(N_WIDE)
  ) u_frame (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .dev_addr_i (dev_addr_i),
    .start_i    (start_i),
    .bit_vld_i  (bit_vld_i),
    .bit_i      (bit_i),
    .rd_data_i  (rd_data),
    .reg_addr_o (reg_addr),
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data),
    .ber_set_o  (ber_set),
    .bit_o      (bit_o),
    .bit_oe_o   (bit_oe_o)
  );

  srl_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NARROW_W(NARROW_W),
    .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR),
    .WIDE_BASE(WIDE_BASE), .N_WIDE(N_WIDE)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .addr_i    (reg_addr),
    .rd_data_o (rd_data),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .ber_set_i (ber_set)
  );

  srl_attn u_attn (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .err_i   (ber_set),
    .start_i (start_i),
    .attn_o  (attn_o)
  );
endmodule

// File: tb/srl_slave_test.sv
module srl_slave_test;
  localparam logic [2:0] OWN = 3'd5;

  logic clk, rst_n, start_i, bit_vld_i, bit_i;
  logic bit_o, bit_oe_o, attn_o;

  srl_slave uut (
    .clk(clk), .rst_n(rst_n), .dev_addr_i(OWN), .start_i(start_i),
    .bit_vld_i(bit_vld_i), .bit_i(bit_i), .bit_o(bit_o),
    .bit_oe_o(bit_oe_o), .attn_o(attn_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    logic  oe;
    logic  b;
    logic  chk_b;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference register state
  logic [7:0]  ctrl_m;
  logic        ber_m;
  logic [15:0] wide_m [2];

  function automatic logic wide_a(input logic [4:0] a);
    return (a == 5'd2) || (a == 5'd3);
  endfunction

  function automatic logic [15:0] model_rd(input logic [4:0] a);
    case (a)
      5'd0:    return {8'h00, ctrl_m};
      5'd1:    return {15'h0, ber_m};
      5'd2:    return wide_m[0];
      5'd3:    return wide_m[1];
      default: return 16'h0;
    endcase
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (bit_vld_i && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (bit_oe_o !== e.oe || (e.chk_b && bit_o !== e.b)) begin
        n_bad++;
        $display("FAIL %s: oe/bit = %b/%b expected %b/%b", e.tag, bit_oe_o, bit_o, e.oe, e.b);
      end
    end
  end

  task automatic check1(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic slot(input logic b, input logic eoe, input logic eb,
                      input logic chk, input string tag);
    exp_t e;
    @(posedge clk); #1;
    bit_i = b;
    bit_vld_i = 1'b1;
    e.oe = eoe; e.b = eb; e.chk_b = chk; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk); #1;
    bit_vld_i = 1'b0;
  endtask

  task automatic send_start();
    @(posedge clk); #1;
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    check1(attn_o, 1'b0, "R8 attn after start");
  endtask

  task automatic header(input logic [2:0] dev, input logic [4:0] a, input logic rw);
    logic [8:0] h;
    h = {dev, a, rw};
    for (int i = 8; i >= 0; i--) slot(h[i], 1'b0, 1'b0, 1'b0, "R1 header");
  endtask

  task automatic rd(input logic [2:0] dev, input logic [4:0] a,
                    input logic ack, input string tag);
    logic hit;
    logic [15:0] v;
    logic p;
    int w;
    hit = (dev == OWN) && (dev != 3'd0);
    w = wide_a(a) ? 16 : 8;
    v = model_rd(a);
    p = ^{dev, a, 1'b1};
    for (int i = 0; i < w; i++) p ^= v[i];
    send_start();
    header(dev, a, 1'b1);
    for (int i = w - 1; i >= 0; i--) slot(1'b0, hit, v[i], hit, tag);
    slot(1'b0, hit, p, hit, "R4 parity");
    slot(ack, 1'b0, 1'b0, 1'b0, "R5 ack slot");
    if (hit && !ack) begin
      ber_m = 1'b1;
      check1(attn_o, 1'b1, "R8 attn after read nack");
    end
  endtask

  task automatic wr(input logic [2:0] dev, input logic [4:0] a, input logic [15:0] d,
                    input logic bad, input string tag);
    logic acc;
    logic p;
    int w;
    acc = ((dev == OWN) && (dev != 3'd0)) || ((dev == 3'd0) && (a == 5'd0));
    w = wide_a(a) ? 16 : 8;
    p = ^{dev, a, 1'b0};
    for (int i = 0; i < w; i++) p ^= d[i];
    p ^= bad;
    send_start();
    header(dev, a, 1'b0);
    for (int i = w - 1; i >= 0; i--) slot(d[i], 1'b0, 1'b0, 1'b0, tag);
    slot(p, 1'b0, 1'b0, 1'b0, tag);
    slot(1'b0, acc, ~bad, acc, "R6 write ack");
    if (acc) begin
      if (bad) begin
        ber_m = 1'b1;
        check1(attn_o, 1'b1, "R8 attn after write nack");
      end else begin
        case (a)
          5'd0: ctrl_m = d[7:0];
          5'd1: if (d[0]) ber_m = 1'b0;
          5'd2: wide_m[0] = d;
          5'd3: wide_m[1] = d;
          default: ;
        endcase
      end
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    finish_run();
  end

  initial begin
    ctrl_m = 8'h00; ber_m = 1'b0; wide_m[0] = 16'h0; wide_m[1] = 16'h0;
    rst_n = 1'b0; start_i = 1'b0; bit_vld_i = 1'b0; bit_i = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check1(bit_oe_o, 1'b0, "R1 reset oe");
    check1(attn_o, 1'b0, "R8 reset attn");

    // R1 / R3 reset contents and basic access
    rd(OWN, 5'd0, 1'b1, "R3 ctrl reset");
    rd(OWN, 5'd2, 1'b1, "R3 wide reset");
    wr(OWN, 5'd0, 16'h00A5, 1'b0, "R1 write ctrl");
    rd(OWN, 5'd0, 1'b1, "R1 read ctrl");
    wr(OWN, 5'd2, 16'h8001, 1'b0, "R3 write wide0");
    rd(OWN, 5'd2, 1'b1, "R3 read wide0");
    wr(OWN, 5'd3, 16'h7FFE, 1'b0, "R3 write wide1");
    rd(OWN, 5'd3, 1'b1, "R3 read wide1");
    rd(OWN, 5'd9, 1'b1, "R3 unmapped");
    rd(OWN, 5'd1, 1'b1, "R3 status clear");

    // R2 silent reads
    rd(3'd0, 5'd2, 1'b1, "R2 broadcast read");
    rd(3'd6, 5'd0, 1'b1, "R2 other device read");
    rd(3'd0, 5'd2, 1'b0, "R2 broadcast read nack");
    rd(OWN, 5'd1, 1'b1, "R2 status after ignored nack");

    // R7 broadcast writes
    wr(3'd0, 5'd0, 16'h003C, 1'b0, "R7 broadcast ctrl");
    rd(OWN, 5'd0, 1'b1, "R7 ctrl updated");
    wr(3'd0, 5'd2, 16'h1234, 1'b0, "R7 broadcast wide ignored");
    rd(OWN, 5'd2, 1'b1, "R7 wide unchanged");
    wr(3'd6, 5'd3, 16'h5555, 1'b0, "R7 other device write");
    rd(OWN, 5'd3, 1'b1, "R7 wide1 unchanged");

    // R6 parity error on write
    wr(OWN, 5'd3, 16'hDEAD, 1'b1, "R6 bad parity");
    rd(OWN, 5'd1, 1'b1, "R6 ber after bad parity");
    rd(OWN, 5'd3, 1'b1, "R6 not committed");
    wr(OWN, 5'd1, 16'h0001, 1'b0, "R5 clear ber");
    rd(OWN, 5'd1, 1'b1, "R5 ber cleared");

    // R5 nack on read, sticky flag
    rd(OWN, 5'd2, 1'b0, "R5 read nack");
    rd(OWN, 5'd1, 1'b1, "R5 ber set");
    wr(OWN, 5'd1, 16'h00FE, 1'b0, "R5 write zero bit");
    rd(OWN, 5'd1, 1'b1, "R5 ber still set");
    wr(OWN, 5'd1, 16'h0001, 1'b0, "R5 clear again");
    rd(OWN, 5'd1, 1'b1, "R5 ber cleared again");

    // R9 start in the middle of a write
    send_start();
    header(OWN, 5'd2, 1'b0);
    for (int i = 0; i < 5; i++) slot(1'b1, 1'b0, 1'b0, 1'b0, "R9 partial");
    rd(OWN, 5'd2, 1'b1, "R9 abort no commit");
    send_start();
    header(OWN, 5'd0, 1'b1);
    slot(1'b0, 1'b1, ctrl_m[7], 1'b1, "R9 partial read");
    wr(OWN, 5'd0, 16'h0081, 1'b0, "R9 write after abort");
    rd(OWN, 5'd0, 1'b1, "R9 decode restarted");

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule